// File: doc/BRIEF.md
# Interrupt Redirection Register Window

This block is the software-facing register file of an I/O interrupt router with a parameterised number of input pins (24 by default). Software never addresses the internal registers directly: it first writes an index into a select register, then reads or writes the register that index names through a single data window. Behind the window sit an identification register, a read-only version word, an arbitration alias of the identification field, and one 64-bit redirection entry per pin. Each entry is reached as two 32-bit halves.

The block sits on a simple strobed bus with one-cycle registered read data. It claims an access only while it is enabled and the address lies inside its mapped range. The whole redirection table and the enable flag are driven out in parallel to the routing logic that resolves destinations. An access through the window with an index that names nothing is absorbed and flagged with a one-cycle pulse.

Top module: `pinroute_regfile`

## Requirements
- R1: A synchronous reset sets every redirection entry to 0x0000_0000_0001_0000, so only the mask bit (bit 16) is 1. It also clears the select and ID registers, enables the block and sets the base to the BASE_ADDR parameter (0xFEC0_0000 by default).
- R2: An access is claimed only when the block is enabled and base <= addr <= base + 0x100 (both ends inclusive). Within that range only addr[7:0] is decoded. An unclaimed write changes nothing and an unclaimed read returns zero.
- R3: Offset 0x00 is the select register. A read returns all 32 bits of the last value written there.
- R4: A read of any offset other than 0x00 and 0x10 returns zero, and a write to such an offset changes no state.
- R5: Select index 0x01 is the version word. It reads 0x0017_0011: NUM_PINS-1 in bits 23:16 and 0x11 in bits 7:0. A write to it changes nothing.
- R6: Select index 0x00 is the ID register. A window write stores wdata[27:24], and a read returns that field in bits 27:24 with all other bits zero. Index 0x02 reads the same value, and a write to index 0x02 changes nothing.
- R7: A select index s >= 0x10 addresses entry (s-0x10)>>1. An even index accesses bits 31:0 and an odd index accesses bits 63:32. A write to one half leaves the other half unchanged.
- R8: Entry i drives redir_tbl[64*i+63 : 64*i] exactly as written. Its fields are: vector in 7:0, delivery mode in 10:8, destination mode in 11, delivery status in 12, polarity in 13, remote IRR in 14, trigger mode in 15 (1 = level), mask in 16, and destination ID in 63:56.
- R9: Some select indices name no register: 0x03 to 0x0F, and any index whose entry number is NUM_PINS or more. A window access with such an index reads zero and its write is dropped. bad_sel is high for exactly the cycle after that access.
- R10: Read data appears on bus_rdata in the cycle after a claimed bus_rd and is zero in every other cycle.
- R11: A cycle with cfg_wr high loads cfg_en into the enable flag and cfg_base into the base address. The new values take effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Bus address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_claim | output | 1 | The current address is claimed by this block |
| cfg_wr | input | 1 | Load enable flag and base address |
| cfg_en | input | 1 | Enable value to load |
| cfg_base | input | ADDR_W | Base address to load |
| map_enable | output | 1 | Enable flag |
| redir_tbl | output | 64*NUM_PINS | All redirection entries, entry i at bits 64*i+63:64*i |
| bad_sel | output | 1 | Pulse after a window access with an unimplemented index |

## Verification
The window is first exercised with each implemented index (ID, version, arbitration alias, even and odd halves of the first and last entries). This separates a wrong index-to-entry mapping from a wrong half selection. A sweep then writes a distinct pattern into every half of every entry, so entries that alias each other or halves that overwrite each other show up in the parallel table output. Boundary cases follow. Indices just past the last entry and inside the 0x03 to 0x0F gap are tried, along with the exact top of the address range and one step beyond it, and accesses while the block is disabled or after it is moved to a new base. These show whether the claim test and the bad-index filter cut at the right values.

// File: rtl/pinroute_pkg.sv
package pinroute_pkg;

    localparam int          REG_W    = 32;
    localparam int          ENT_W    = 64;
    localparam logic [7:0]  OFF_SEL  = 8'h00;
    localparam logic [7:0]  OFF_WIN  = 8'h10;
    localparam logic [7:0]  VER_CODE = 8'h11;
    localparam logic [31:0] SPAN     = 32'h100;
    localparam logic [31:0] IDX_TBL  = 32'h10;

    typedef enum logic [2:0] {
        WK_ID,
        WK_VER,
        WK_ARB,
        WK_LO,
        WK_HI,
        WK_BAD
    } win_kind_e;

    // one redirection entry; the bit positions are decoded by the router
    typedef struct packed {
        logic [7:0]  dest;
        logic [38:0] rsvd;
        logic        mask;
        logic        trig;
        logic        rirr;
        logic        pol;
        logic        dstat;
        logic        dmode;
        logic [2:0]  dlv;
        logic [7:0]  vec;
    } redir_t;

    function automatic redir_t redir_reset_val();
        redir_t r;
        r      = '0;
        r.mask = 1'b1;
        return r;
    endfunction

    function automatic logic [REG_W-1:0] ver_word(input int pins);
        return {8'h00, 8'(pins - 1), 8'h00, VER_CODE};
    endfunction

endpackage

// File: rtl/pinroute_addr_dec.sv
module pinroute_addr_dec
    import pinroute_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  logic              en,
    output logic              claim,
    output logic              is_sel,
    output logic              is_win
);
    logic [ADDR_W:0] top_lim;

    // widened by one bit so a base near the top of the space cannot wrap
    assign top_lim = {1'b0, base} + (ADDR_W+1)'(SPAN);
    assign claim   = en && (addr >= base) && ({1'b0, addr} <= top_lim);
    assign is_sel  = (addr[7:0] == OFF_SEL);
    assign is_win  = (addr[7:0] == OFF_WIN);
endmodule

// File: rtl/pinroute_win_dec.sv
module pinroute_win_dec
    import pinroute_pkg::*;
#(
    parameter int NUM_PINS = 24,
    localparam int IDX_W   = $clog2(NUM_PINS)
) (
    input  logic [REG_W-1:0] sel,
    output win_kind_e        kind,
    output logic [IDX_W-1:0] idx
);
    logic [REG_W-1:0] ent_no;

    assign ent_no = (sel - IDX_TBL) >> 1;

    always_comb begin
        idx  = '0;
        kind = WK_BAD;
        if (sel == 32'd0) begin
            kind = WK_ID;
        end else if (sel == 32'd1) begin
            kind = WK_VER;
        end else if (sel == 32'd2) begin
            kind = WK_ARB;
        end else if (sel >= IDX_TBL && ent_no < REG_W'(NUM_PINS)) begin
            idx  = IDX_W'(ent_no);
            kind = sel[0] ? WK_HI : WK_LO;
        end
    end
endmodule

// File: rtl/pinroute_redir_bank.sv
module pinroute_redir_bank
    import pinroute_pkg::*;
#(
    parameter int NUM_PINS = 24,
    localparam int IDX_W   = $clog2(NUM_PINS)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic                      wr_hi,
    input  logic [IDX_W-1:0]          idx,
    input  logic [REG_W-1:0]          wr_data,
    output logic [ENT_W-1:0]          rd_ent,
    output logic [NUM_PINS*ENT_W-1:0] tbl_flat
);
    redir_t ent [NUM_PINS];

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                ent[g] <= redir_reset_val();
            end else if (wr_en && idx == IDX_W'(g)) begin
                if (wr_hi) ent[g][63:32] <= wr_data;
                else       ent[g][31:0]  <= wr_data;
            end
        end
        assign tbl_flat[g*ENT_W +: ENT_W] = ent[g];
    end

    assign rd_ent = ent[idx];
endmodule

// File: rtl/pinroute_regfile.sv
module pinroute_regfile
    import pinroute_pkg::*;
#(
    parameter int                NUM_PINS  = 24,
    parameter int                ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = ADDR_W'(32'hFEC0_0000),
    localparam int               IDX_W     = $clog2(NUM_PINS)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic                      bus_wr,
    input  logic                      bus_rd,
    input  logic [31:0]               bus_wdata,
    output logic [31:0]               bus_rdata,
    output logic                      bus_claim,
    input  logic                      cfg_wr,
    input  logic                      cfg_en,
    input  logic [ADDR_W-1:0]         cfg_base,
    output logic                      map_enable,
    output logic [NUM_PINS*64-1:0]    redir_tbl,
    output logic                      bad_sel
);
    logic              en_q;
    logic [ADDR_W-1:0] base_q;
    logic [REG_W-1:0]  sel_q;
    logic [3:0]        id_q;
    logic              claim, is_sel, is_win;
    win_kind_e         kind;
    logic [IDX_W-1:0]  idx;
    logic [ENT_W-1:0]  ent_rd;
    logic              wr_act, rd_act, ent_wr;
    logic [REG_W-1:0]  win_rd, rd_next;

    pinroute_addr_dec #(.ADDR_W(ADDR_W)) u_adec (
        .addr   (bus_addr),
        .base   (base_q),
        .en     (en_q),
        .claim  (claim),
        .is_sel (is_sel),
        .is_win (is_win)
    );

    pinroute_win_dec #(.NUM_PINS(NUM_PINS)) u_wdec (
        .sel  (sel_q),
        .kind (kind),
        .idx  (idx)
    );

    assign wr_act = bus_wr && claim;
    assign rd_act = bus_rd && claim;
    assign ent_wr = wr_act && is_win && (kind == WK_LO || kind == WK_HI);

    pinroute_redir_bank #(.NUM_PINS(NUM_PINS)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (ent_wr),
        .wr_hi    (kind == WK_HI),
        .idx      (idx),
        .wr_data  (bus_wdata),
        .rd_ent   (ent_rd),
        .tbl_flat (redir_tbl)
    );

    always_comb begin
        unique case (kind)
            WK_ID, WK_ARB: win_rd = {4'h0, id_q, 24'h0};
            WK_VER:        win_rd = ver_word(NUM_PINS);
            WK_LO:         win_rd = ent_rd[31:0];
            WK_HI:         win_rd = ent_rd[63:32];
            default:       win_rd = '0;
        endcase
    end

    always_comb begin
        rd_next = '0;
        if (rd_act) begin
            if (is_sel)      rd_next = sel_q;
            else if (is_win) rd_next = win_rd;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q      <= 1'b1;
            base_q    <= BASE_ADDR;
            sel_q     <= '0;
            id_q      <= '0;
            bus_rdata <= '0;
            bad_sel   <= 1'b0;
        end else begin
            if (cfg_wr) begin
                en_q   <= cfg_en;
                base_q <= cfg_base;
            end
            if (wr_act && is_sel)
                sel_q <= bus_wdata;
            if (wr_act && is_win && kind == WK_ID)
                id_q <= bus_wdata[27:24];
            bus_rdata <= rd_next;
            bad_sel   <= (wr_act || rd_act) && is_win && (kind == WK_BAD);
        end
    end

    assign bus_claim  = claim;
    assign map_enable = en_q;
endmodule

// File: rtl/pinroute_checker.sv
module pinroute_checker
    import pinroute_pkg::*;
#(
    parameter int NUM_PINS = 24
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   bus_wr,
    input logic                   bus_rd,
    input logic [31:0]            bus_wdata,
    input logic [31:0]            bus_rdata,
    input logic                   claim,
    input logic                   is_sel,
    input logic                   is_win,
    input win_kind_e              kind,
    input logic [31:0]            sel_q,
    input logic                   map_enable,
    input logic [NUM_PINS*64-1:0] redir_tbl,
    input logic                   bad_sel
);
    assert_rst_state_R1: assert property (@(posedge clk)
        rst |=> (bus_rdata == 32'h0 && !bad_sel && map_enable &&
                 sel_q == 32'h0 && redir_tbl[63:0] == 64'h1_0000));

    assert_disabled_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (!map_enable && bus_wr) |=> ($stable(redir_tbl) && $stable(sel_q)));

    assert_sel_store_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && claim && is_sel) |=> (sel_q == $past(bus_wdata)));

    assert_ver_readonly_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && claim && is_win && kind == WK_VER) |=> $stable(redir_tbl));

    assert_bad_drop_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && claim && is_win && kind == WK_BAD) |=> ($stable(redir_tbl) && bad_sel));

    assert_bad_cause_R9: assert property (@(posedge clk) disable iff (rst)
        bad_sel |-> $past(bus_rd || bus_wr));

    assert_rdata_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> (bus_rdata == 32'h0));
endmodule

bind pinroute_regfile pinroute_checker #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .claim      (claim),
    .is_sel     (is_sel),
    .is_win     (is_win),
    .kind       (kind),
    .sel_q      (sel_q),
    .map_enable (map_enable),
    .redir_tbl  (redir_tbl),
    .bad_sel    (bad_sel)
);

// File: tb/pinroute_regfile_bench.sv
module pinroute_regfile_bench;
    localparam int          NP    = 24;
    localparam logic [31:0] BASE0 = 32'hFEC0_0000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [31:0]       bus_addr = '0;
    logic              bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              bus_claim;
    logic              cfg_wr = 1'b0, cfg_en = 1'b0;
    logic [31:0]       cfg_base = '0;
    logic              map_enable;
    logic [NP*64-1:0]  redir_tbl;
    logic              bad_sel;

    always #10 clk = ~clk;

    pinroute_regfile u_pinroute_regfile (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_claim(bus_claim),
        .cfg_wr(cfg_wr), .cfg_en(cfg_en), .cfg_base(cfg_base),
        .map_enable(map_enable), .redir_tbl(redir_tbl), .bad_sel(bad_sel)
    );

    // behavioural reference state
    logic [63:0] m_tbl [NP];
    logic [31:0] m_sel;
    logic [3:0]  m_id;
    logic        m_en;
    logic [31:0] m_base;

    int checks = 0;
    int bad    = 0;
    bit done   = 0;

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_tbl(input string req);
        int mism = -1;
        checks++;
        for (int i = 0; i < NP; i++)
            if (redir_tbl[i*64 +: 64] !== m_tbl[i] && mism < 0) mism = i;
        if (mism >= 0) begin
            bad++;
            $display("FAIL %s table entry %0d actual=%h expected=%h",
                     req, mism, redir_tbl[mism*64 +: 64], m_tbl[mism]);
        end
    endtask

    function automatic bit m_claim(input logic [31:0] a);
        return m_en && a >= m_base && {1'b0, a} <= {1'b0, m_base} + 33'h100;
    endfunction

    function automatic bit m_sel_bad();
        if (m_sel <= 2) return 0;
        if (m_sel < 16) return 1;
        return ((m_sel - 32'd16) >> 1) >= NP;
    endfunction

    function automatic logic [31:0] m_win_read();
        int e;
        if (m_sel == 0 || m_sel == 2) return {4'h0, m_id, 24'h0};
        if (m_sel == 1) return ((NP - 1) << 16) | 32'h11;
        if (m_sel_bad()) return 32'h0;
        e = int'((m_sel - 32'd16) >> 1);
        return m_sel[0] ? m_tbl[e][63:32] : m_tbl[e][31:0];
    endfunction

    task automatic op(input bit wr, input bit rd, input logic [31:0] a,
                      input logic [31:0] d, input string req);
        logic [31:0] exp_rd = '0;
        bit          exp_bad;
        bit          c = m_claim(a);
        logic [7:0]  off = a[7:0];
        int          e;
        if (rd && c) exp_rd = (off == 8'h00) ? m_sel : (off == 8'h10) ? m_win_read() : 32'h0;
        exp_bad = c && (rd || wr) && off == 8'h10 && m_sel_bad();
        if (wr && c) begin
            if (off == 8'h00) m_sel = d;
            else if (off == 8'h10) begin
                if (m_sel == 0) m_id = d[27:24];
                else if (m_sel >= 16 && !m_sel_bad()) begin
                    e = int'((m_sel - 32'd16) >> 1);
                    if (m_sel[0]) m_tbl[e][63:32] = d;
                    else          m_tbl[e][31:0]  = d;
                end
            end
        end
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = wr; bus_rd = rd;
        @(negedge clk);
        bus_wr = 0; bus_rd = 0;
        check(req, "rdata", 64'(bus_rdata), 64'(exp_rd));
        check(req, "bad_sel", 64'(bad_sel), 64'(exp_bad));
        check_tbl(req);
    endtask

    task automatic set_cfg(input bit en, input logic [31:0] b);
        @(negedge clk);
        cfg_wr = 1; cfg_en = en; cfg_base = b;
        @(negedge clk);
        cfg_wr = 0;
        m_en = en; m_base = b;
        check("R11", "map_enable", 64'(map_enable), 64'(en));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            checks++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NP; i++) m_tbl[i] = 64'h1_0000;
        m_sel = 0; m_id = 0; m_en = 1; m_base = BASE0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1 reset state
        check("R1", "map_enable", 64'(map_enable), 64'd1);
        check("R1", "rdata", 64'(bus_rdata), 64'd0);
        check("R1", "bad_sel", 64'(bad_sel), 64'd0);
        for (int i = 0; i < NP; i++)
            check("R1", "entry", redir_tbl[i*64 +: 64], 64'h1_0000);
        op(0, 1, BASE0, 0, "R1");
        op(0, 1, BASE0 + 32'h10, 0, "R1");

        // R3 select register
        op(1, 0, BASE0, 32'hDEAD_BEEF, "R3");
        op(0, 1, BASE0, 0, "R3");

        // R5 version
        op(1, 0, BASE0, 32'h1, "R5");
        op(0, 1, BASE0 + 32'h10, 0, "R5");
        check("R5", "literal", 64'(bus_rdata), 64'h0017_0011);
        op(1, 0, BASE0 + 32'h10, 32'hFFFF_FFFF, "R5");
        op(0, 1, BASE0 + 32'h10, 0, "R5");

        // R6 ID and arbitration alias
        op(1, 0, BASE0, 32'h0, "R6");
        op(1, 0, BASE0 + 32'h10, 32'hA5FF_FFFF, "R6");
        op(0, 1, BASE0 + 32'h10, 0, "R6");
        check("R6", "id literal", 64'(bus_rdata), 64'h0500_0000);
        op(1, 0, BASE0, 32'h2, "R6");
        op(0, 1, BASE0 + 32'h10, 0, "R6");
        op(1, 0, BASE0 + 32'h10, 32'h3F00_0000, "R6");
        op(0, 1, BASE0 + 32'h10, 0, "R6");

        // R7 / R8 halves and field positions
        op(1, 0, BASE0, 32'h10, "R7");
        op(1, 0, BASE0 + 32'h10, 32'h0000_80F3, "R8");
        op(1, 0, BASE0, 32'h11, "R7");
        op(1, 0, BASE0 + 32'h10, 32'hAB00_0000, "R8");
        check("R8", "trigger bit15", 64'(redir_tbl[15]), 64'd1);
        check("R8", "vector 7:0", 64'(redir_tbl[7:0]), 64'hF3);
        check("R8", "mask bit16", 64'(redir_tbl[16]), 64'd0);
        check("R8", "dest 63:56", 64'(redir_tbl[63:56]), 64'hAB);
        op(0, 1, BASE0 + 32'h10, 0, "R7");
        op(1, 0, BASE0, 32'h3E, "R7");
        op(1, 0, BASE0 + 32'h10, 32'h1234_5678, "R7");
        op(1, 0, BASE0, 32'h3F, "R7");
        op(1, 0, BASE0 + 32'h10, 32'h9ABC_DEF0, "R7");
        op(1, 0, BASE0, 32'h3E, "R7");
        op(1, 0, BASE0 + 32'h10, 32'h0001_0000, "R7");
        check("R7", "hi kept", redir_tbl[23*64+32 +: 32], 64'h9ABC_DEF0);
        for (int i = 0; i < NP; i++) begin
            op(1, 0, BASE0, 32'h10 + 32'(2*i), "R7");
            op(1, 0, BASE0 + 32'h10, 32'(i) * 32'h0101_0101 ^ 32'h5A, "R7");
            op(1, 0, BASE0, 32'h11 + 32'(2*i), "R7");
            op(1, 0, BASE0 + 32'h10, ~(32'(i) * 32'h0303_0303), "R7");
        end
        op(1, 0, BASE0, 32'h2B, "R7");
        op(0, 1, BASE0 + 32'h10, 0, "R7");

        // R9 unimplemented indices
        op(1, 0, BASE0, 32'h5, "R9");
        op(0, 1, BASE0 + 32'h10, 0, "R9");
        op(1, 0, BASE0 + 32'h10, 32'h1111_1111, "R9");
        op(1, 0, BASE0, 32'h40, "R9");
        op(1, 0, BASE0 + 32'h10, 32'h2222_2222, "R9");
        op(0, 1, BASE0 + 32'h10, 0, "R9");
        op(1, 0, BASE0, 32'hFFFF_FFFF, "R9");
        op(1, 0, BASE0 + 32'h10, 32'h3333_3333, "R9");
        op(1, 0, BASE0, 32'h0F, "R9");
        op(0, 1, BASE0 + 32'h10, 0, "R9");
        check("R9", "pulse width", 64'(bad_sel), 64'd1);
        @(negedge clk);
        check("R9", "pulse ends", 64'(bad_sel), 64'd0);

        // R4 other offsets
        op(1, 0, BASE0, 32'h12, "R4");
        op(0, 1, BASE0 + 32'h20, 0, "R4");
        op(1, 0, BASE0 + 32'h04, 32'h7777_7777, "R4");
        op(1, 0, BASE0 + 32'h11, 32'h7777_7777, "R4");
        op(0, 1, BASE0, 0, "R4");

        // R2 address range
        op(1, 0, BASE0 + 32'h200, 32'h55, "R2");
        op(0, 1, BASE0 + 32'h200, 0, "R2");
        op(1, 0, BASE0 - 32'h100 + 32'h10, 32'h4444_4444, "R2");
        op(1, 0, BASE0 + 32'h100, 32'h14, "R2");
        op(0, 1, BASE0, 0, "R2");

        // R10 read data lasts one cycle
        op(0, 1, BASE0, 0, "R10");
        @(negedge clk);
        check("R10", "rdata idle", 64'(bus_rdata), 64'd0);

        // R11 configuration
        set_cfg(0, BASE0);
        op(1, 0, BASE0, 32'h99, "R11");
        op(0, 1, BASE0, 0, "R11");
        set_cfg(1, 32'h1000_0000);
        op(1, 0, 32'h1000_0000, 32'h16, "R11");
        op(0, 1, 32'h1000_0000, 0, "R11");
        op(0, 1, BASE0, 0, "R11");

        done = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule